// File: doc/BRIEF.md
# ADC Conversion Result Byte Registers

This block stores the most recent analog-to-digital conversion result and lets a byte-wide processor bus read it as two read-only 8-bit registers. One register holds the upper byte and the other holds the lower byte. An alignment input selects the layout. With left alignment, the result is packed against the top of the 16-bit pair. With right alignment, it is packed against the bottom. Every bit outside the result reads as zero.

A conversion can finish while software is between its two byte reads. The block protects the result against this. Which byte must be read first depends on the alignment. Reading that byte takes a snapshot of the whole result and sets a lock. Reading the other byte then returns the snapshot and releases the lock. A conversion that finishes while the lock is held waits in a one-entry holding slot. It becomes visible when the lock releases. Results are taken in only when the mode input says that the converter runs in single or non-buffered continuous mode.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, a read of either data register returns 0x00 until a conversion has been accepted.
- R2: A read with `rd_en` high returns data on `rd_data` in the following cycle. Address 0x24 returns the upper byte, address 0x25 returns the lower byte, and any other address returns 0x00. `rd_data` holds its value in cycles without a read.
- R3: With `align_left`=1, the treatment is as if the RES_W-bit result were shifted left by 16−RES_W into a 16-bit word. Address 0x24 returns bits 15:8 of that word and address 0x25 returns bits 7:0, whose lowest 16−RES_W bits are zero.
- R4: With `align_left`=0, the treatment is as if the result were zero-extended to 16 bits. Address 0x25 returns bits 7:0 and address 0x24 returns bits 15:8, whose bits above position RES_W−9 are zero.
- R5: The first byte is 0x24 when `align_left`=1 and 0x25 when `align_left`=0. The second byte is the other address. Reading the first byte while unlocked snapshots the result and sets the lock. Reading the second byte while locked returns the snapshot and clears the lock.
- R6: A conversion accepted while the lock is held leaves the readable result unchanged and goes into a one-entry slot, where a later conversion overwrites an earlier one. That slot is copied into the readable result when the lock clears. A conversion arriving in the same cycle as the unlocking read wins over the slot.
- R7: `conv_done` has no effect while `mode_ok` is 0.
- R8: A change of `align_left` changes the formatting and the first/second assignment from the next read onward. It does not clear the lock.
- R9: A read of the second byte while unlocked returns the current result and leaves the block unlocked.
- R10: When a conversion arrives in the same cycle as an unlocked first-byte read, the read returns the previous result and the new result is held until the lock clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion result is on `conv_data` |
| conv_data | input | RES_W | Conversion result word |
| mode_ok | input | 1 | High when the converter runs in single or non-buffered continuous mode |
| align_left | input | 1 | 1 selects left alignment, 0 selects right alignment |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Registered read data |

## Verification
The checker watches four things on every cycle. It checks that the lock is set and cleared by the correct first and second reads. It checks that the readable result stays frozen while locked. It checks that the holding slot is never occupied without a lock. It checks that the zero bits of the partially filled byte really read as zero in both alignments. Other behaviours can only be shown by the bench's scenarios. These include the snapshot value returned across a conversion, the newest-wins holding slot, the effect of `mode_ok`, an alignment flip during a lock, and a conversion arriving in the same cycle as a read. The bench compares them against its own model of the requirements.

// File: rtl/adc_result_fmt.sv
// adc_result_fmt
// Purpose : turns an RES_W-bit conversion result into the upper and lower
//           register bytes for the selected alignment.
// Assumes : 8 < RES_W <= 16. Purely combinational.
module adc_result_fmt #(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] word_i,
    input  logic             left_i,
    output logic [7:0]       hi_o,
    output logic [7:0]       lo_o
);
    localparam int PAD_W = 16 - RES_W;

    logic [15:0] ext_w;
    logic [15:0] packed_w;

    // Place the result at the top or bottom of a 16-bit pair
    always_comb begin
        ext_w    = 16'(word_i);
        packed_w = left_i ? (ext_w << PAD_W) : ext_w;
        hi_o     = packed_w[15:8];
        lo_o     = packed_w[7:0];
    end
endmodule

// File: rtl/adc_result_lock.sv
// adc_result_lock
// Purpose : holds the live result, the snapshot taken by a first-byte read,
//           the lock flag and a one-entry slot for results that arrive while
//           locked.
// Assumes : first_rd_i and second_rd_i are never high together. conv_i is
//           already qualified by the mode input.
module adc_result_lock #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_i,
    input  logic [RES_W-1:0] conv_data_i,
    input  logic             first_rd_i,
    input  logic             second_rd_i,
    output logic [RES_W-1:0] src_o,
    output logic [RES_W-1:0] live_o,
    output logic             lock_o,
    output logic             pend_v_o
);
    logic [RES_W-1:0] live_q;
    logic [RES_W-1:0] shadow_q;
    logic [RES_W-1:0] pend_q;
    logic             lock_q;
    logic             pend_v_q;
    logic             lock_set;
    logic             lock_clr;
    logic             hold;

    // Decode lock transitions and whether a new result must wait
    always_comb begin
        lock_set = first_rd_i & ~lock_q;
        lock_clr = second_rd_i & lock_q;
        hold     = (lock_q & ~lock_clr) | lock_set;
    end

    // Lock flag and snapshot register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            shadow_q <= '0;
        end else if (lock_set) begin
            lock_q   <= 1'b1;
            shadow_q <= live_q;
        end else if (lock_clr) begin
            lock_q   <= 1'b0;
        end
    end

    // Live result and holding slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (conv_i) begin
            if (hold) begin
                pend_q   <= conv_data_i;
                pend_v_q <= 1'b1;
            end else begin
                live_q   <= conv_data_i;
                pend_v_q <= 1'b0;
            end
        end else if (lock_clr && pend_v_q) begin
            live_q   <= pend_q;
            pend_v_q <= 1'b0;
        end
    end

    // Reads see the snapshot while locked, the live result otherwise
    always_comb begin
        src_o    = lock_q ? shadow_q : live_q;
        live_o   = live_q;
        lock_o   = lock_q;
        pend_v_o = pend_v_q;
    end
endmodule

// File: rtl/adc_result_regs.sv
// adc_result_regs
// Purpose : presents a conversion result as two read-only byte registers with
//           alignment selection and a two-read coherency lock.
// Assumes : 8 < RES_W <= 16. Read data is registered, one cycle after rd_en.
module adc_result_regs #(
    parameter int                RES_W   = 10,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h24,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              mode_ok,
    input  logic              align_left,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic              hit_hi;
    logic              hit_lo;
    logic              first_rd;
    logic              second_rd;
    logic              conv_ok;
    logic [RES_W-1:0]  src_w;
    logic [RES_W-1:0]  live_w;
    logic              lock_w;
    logic              pend_w;
    logic [7:0]        hi_b;
    logic [7:0]        lo_b;
    logic [7:0]        rd_data_q;

    // Address decode and first/second byte roles from the alignment
    always_comb begin
        hit_hi    = rd_en && (rd_addr == HI_ADDR);
        hit_lo    = rd_en && (rd_addr == LO_ADDR);
        first_rd  = align_left ? hit_hi : hit_lo;
        second_rd = align_left ? hit_lo : hit_hi;
        conv_ok   = conv_done & mode_ok;
    end

    adc_result_lock #(.RES_W(RES_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_i     (conv_ok),
        .conv_data_i(conv_data),
        .first_rd_i (first_rd),
        .second_rd_i(second_rd),
        .src_o      (src_w),
        .live_o     (live_w),
        .lock_o     (lock_w),
        .pend_v_o   (pend_w)
    );

    adc_result_fmt #(.RES_W(RES_W)) u_fmt (
        .word_i(src_w),
        .left_i(align_left),
        .hi_o  (hi_b),
        .lo_o  (lo_b)
    );

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= 8'h00;
        end else if (rd_en) begin
            rd_data_q <= hit_hi ? hi_b : (hit_lo ? lo_b : 8'h00);
        end
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/adc_result_regs_chk.sv
// adc_result_regs_chk
// Purpose : cycle-by-cycle properties of the result registers, bound to the top.
// Assumes : same parameters as the bound instance.
module adc_result_regs_chk #(
    parameter int                RES_W   = 10,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h24,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              align_left,
    input logic [7:0]        rd_data,
    input logic              lock_w,
    input logic              pend_w,
    input logic [RES_W-1:0]  live_w
);
    localparam logic [15:0] HI_ZERO = 16'h00FF << (RES_W - 8);
    localparam logic [15:0] LO_ZERO = (16'h0001 << (16 - RES_W)) - 16'h0001;

    logic first_hit;
    logic second_hit;

    // Byte roles as the requirements define them
    always_comb begin
        first_hit  = rd_en && (rd_addr == (align_left ? HI_ADDR : LO_ADDR));
        second_hit = rd_en && (rd_addr == (align_left ? LO_ADDR : HI_ADDR));
    end

    // R5
    first_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_hit && !lock_w |=> lock_w);

    // R5
    second_read_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        second_hit && lock_w |=> !lock_w);

    // R6
    frozen_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w && !second_hit |=> $stable(live_w));

    // R6
    slot_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_w |-> lock_w);

    // R4
    right_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == HI_ADDR && !align_left |=> (rd_data & HI_ZERO[7:0]) == 8'h00);

    // R3
    left_lo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == LO_ADDR && align_left |=> (rd_data & LO_ZERO[7:0]) == 8'h00);
endmodule

bind adc_result_regs adc_result_regs_chk #(
    .RES_W(RES_W), .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .align_left(align_left),
    .rd_data   (rd_data),
    .lock_w    (lock_w),
    .pend_w    (pend_w),
    .live_w    (live_w)
);

// File: tb/adc_result_regs_tb.sv
module adc_result_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 10;
    localparam logic [7:0] AH = 8'h24;
    localparam logic [7:0] AL = 8'h25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_done = 1'b0;
    logic [RW-1:0] conv_data = '0;
    logic          mode_ok = 1'b1;
    logic          align_left = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_addr = 8'h00;
    logic [7:0]    rd_data;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model state
    logic [RW-1:0] m_live = '0, m_shadow = '0, m_pend = '0;
    logic          m_lock = 1'b0, m_pend_v = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_result_regs #(.RES_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .mode_ok(mode_ok), .align_left(align_left), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] fmt(logic [RW-1:0] w, logic left, logic [7:0] a);
        logic [15:0] e;
        e = left ? (16'(w) << (16 - RW)) : 16'(w);
        if (a == AH) return e[15:8];
        if (a == AL) return e[7:0];
        return 8'h00;
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One cycle: drive, clock, update model, check the read result
    task automatic step(logic cv, logic [RW-1:0] d, logic md, logic al,
                        logic rd, logic [7:0] a, string tag);
        logic [7:0] exp;
        logic first, second, cvk, lk;
        conv_done = cv; conv_data = d; mode_ok = md; align_left = al;
        rd_en = rd; rd_addr = a;
        exp    = fmt(m_lock ? m_shadow : m_live, al, a);
        first  = rd && (a == (al ? AH : AL));
        second = rd && (a == (al ? AL : AH));
        cvk    = cv && md;
        @(posedge clk);
        if (first && !m_lock) begin m_shadow = m_live; m_lock = 1'b1; lk = 1'b1; end
        else if (second && m_lock) begin m_lock = 1'b0; lk = 1'b0;
            if (cvk) begin m_live = d; m_pend_v = 1'b0; end
            else if (m_pend_v) begin m_live = m_pend; m_pend_v = 1'b0; end
            cvk = 1'b0;
        end else lk = m_lock;
        if (cvk) begin
            if (lk) begin m_pend = d; m_pend_v = 1'b1; end
            else begin m_live = d; m_pend_v = 1'b0; end
        end
        @(negedge clk);
        conv_done = 1'b0; rd_en = 1'b0;
        if (rd) check(rd_data, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rd_data, 8'h00, "R1 reset value");
        step(0, 0, 1, 0, 1, AH, "R1 hi before conversion");
        check(rd_data, 8'h00, "R1 literal");
        // R4 right alignment, low byte first
        step(1, 10'h2D5, 1, 0, 0, AH, "R4");
        step(0, 0, 1, 0, 1, AL, "R4 low byte");
        check(rd_data, 8'hD5, "R4 literal low");
        step(0, 0, 1, 0, 1, AH, "R4 high byte");
        check(rd_data, 8'h02, "R4 literal high");
        // R2 unmapped address
        step(0, 0, 1, 0, 1, 8'h26, "R2 unmapped");
        // R3 left alignment and R5 snapshot across a conversion
        step(0, 0, 1, 1, 1, AH, "R3 high byte");
        check(rd_data, 8'hB5, "R3 literal high");
        step(1, 10'h111, 1, 1, 0, AH, "R6");
        step(0, 0, 1, 1, 1, AL, "R5 snapshot low");
        check(rd_data, 8'h40, "R5 literal low");
        step(0, 0, 1, 1, 1, AH, "R6 pending applied");
        check(rd_data, 8'h44, "R6 literal");
        step(0, 0, 1, 1, 1, AL, "R5 unlock");
        // R7 mode off
        step(1, 10'h3FF, 0, 1, 0, AH, "R7");
        step(0, 0, 1, 1, 1, AH, "R7 ignored conversion");
        check(rd_data, 8'h44, "R7 literal");
        // R6 newest wins in slot
        step(1, 10'h0AA, 1, 1, 0, AH, "R6");
        step(1, 10'h155, 1, 1, 0, AH, "R6");
        step(0, 0, 1, 1, 1, AL, "R6 unlock");
        step(0, 0, 1, 1, 1, AH, "R6 newest wins");
        check(rd_data, 8'h55, "R6 literal newest");
        step(0, 0, 1, 1, 1, AL, "R6 unlock");
        // R8 flip alignment during lock
        step(0, 0, 1, 1, 1, AH, "R8 lock");
        step(0, 0, 1, 0, 1, AL, "R8 still locked");
        step(0, 0, 1, 0, 1, AH, "R8 second in right");
        check(rd_data, 8'h01, "R8 literal");
        // R9 second byte without lock
        step(0, 0, 1, 0, 1, AH, "R9 unlocked second");
        step(1, 10'h3C3, 1, 0, 0, AH, "R9");
        step(0, 0, 1, 0, 1, AH, "R9 live update");
        check(rd_data, 8'h03, "R9 literal");
        // R10 conversion with first read
        step(1, 10'h0F0, 1, 0, 1, AL, "R10 old value");
        check(rd_data, 8'hC3, "R10 literal");
        step(0, 0, 1, 0, 1, AH, "R10 second");
        step(0, 0, 1, 0, 1, AL, "R10 new value");
        check(rd_data, 8'hF0, "R10 literal new");
        step(0, 0, 1, 0, 1, AH, "R10 unlock");
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            int r;
            r = $urandom_range(0, 9);
            a = (r < 4) ? AH : (r < 9) ? AL : 8'h27;
            step(($urandom_range(0, 2) == 0), RW'($urandom), ($urandom_range(0, 7) != 0),
                 (($urandom_range(0, 15) == 0) ? ~align_left : align_left),
                 ($urandom_range(0, 1) == 1), a, "R2 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule